// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit sits beside the fetch and load/store stages of a small 32-bit core and watches both for addresses a debugger has armed. It holds a set of instruction breakpoint slots, each an address plus an enable bit, and a set of data watchpoint slots, each a byte address plus a direction mode. Every cycle it compares the fetch PC against the armed breakpoints and the load/store address against the armed watchpoints. It raises an event for the exception logic in the same cycle, before the instruction issues or the access commits.

Slots are loaded through a single-cycle write port that selects the slot kind, the slot index, the address and a two-bit control field. A slot is cleared by writing a zero control field. Clearing a slot that is already empty changes nothing. The match outputs are combinational functions of the slot registers and the qualified request, so the core can gate a store in the cycle it is presented. Breakpoints take priority when both kinds hit together. Any matching access is blocked regardless of which event is reported.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is empty, so `bp_hit`, `wp_hit` and `mem_inhibit` stay 0 for any PC or data address until a slot is written.
- R2: `bp_hit` is 1 in the cycle `fetch_valid` is 1 and `fetch_pc` exactly equals the address of a breakpoint slot whose enable bit is set. An address one word off, or a slot with its enable bit clear, gives no hit.
- R3: A watchpoint mode is encoded as follows: 2'b00 off, 2'b01 loads only, 2'b10 stores only, 2'b11 both. `mem_wr`=1 marks a store and 0 marks a load. An access in a direction the mode excludes gives no hit.
- R4: A watchpoint in mode off never hits, whatever address it holds.
- R5: A watchpoint covers one byte. An access covers the bytes of its naturally aligned container: `mem_size` 0 is a byte, 1 is a halfword, and 2 or 3 is a word, with the low address bits ignored. The slot hits only if its byte lies inside that container.
- R6: `mem_inhibit` is 1 in the same cycle as any qualified watchpoint match, so a matching store is blocked before it takes effect.
- R7: `wp_hit` requires at least one armed watchpoint to match. Several slots matching in one cycle still produce a single `wp_hit`.
- R8: When a breakpoint and a watchpoint match in the same cycle, only `bp_hit` is raised and `wp_hit` stays 0, while `mem_inhibit` is still 1. `mem_inhibit` without `bp_hit` always comes with `wp_hit`.
- R9: A write with `cfg_we`=1 loads the slot chosen by `cfg_kind` (0 breakpoint, 1 watchpoint) and `cfg_idx`, using `cfg_addr` and `cfg_ctrl`. For a breakpoint, `cfg_ctrl[0]` is the enable bit; for a watchpoint, `cfg_ctrl` is the mode. The write takes effect from the cycle after it.
- R10: With `fetch_valid` at 0 no `bp_hit` occurs. With `mem_valid` at 0 neither `wp_hit` nor `mem_inhibit` occurs.
- R11: Writing or clearing one slot leaves every other slot unchanged, including a slot of the other kind that has the same index. Clearing an already empty slot has no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_kind | input | 1 | 0 selects a breakpoint slot, 1 selects a watchpoint slot |
| cfg_idx | input | IDX_W | Slot index |
| cfg_addr | input | ADDR_W | Address loaded into the slot |
| cfg_ctrl | input | 2 | Breakpoint enable in bit 0, or watchpoint mode |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | ADDR_W | Address of the instruction about to execute |
| mem_valid | input | 1 | Load/store request is valid this cycle |
| mem_wr | input | 1 | 1 for a store, 0 for a load |
| mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| mem_addr | input | ADDR_W | Load/store byte address |
| bp_hit | output | 1 | Breakpoint event |
| wp_hit | output | 1 | Watchpoint event |
| mem_inhibit | output | 1 | Block the current access |

## Verification
A breakpoint match on the fetch PC and a watchpoint match on the data address can occur in the same cycle, because they come from two different instructions in the pipeline. The bench arms both and presents a matching PC together with a matching load. It expects `bp_hit` alone, with `wp_hit` low and `mem_inhibit` still high. It then repeats the same data access with `fetch_valid` dropped and expects the watchpoint event to reappear. A second overlap, two watchpoint slots covering the same word, is provoked with a word load and is judged by a single `wp_hit`.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

   typedef enum logic [1:0] {
      WP_OFF = 2'b00,
      WP_RD  = 2'b01,
      WP_WR  = 2'b10,
      WP_RW  = 2'b11
   } wp_mode_e;

   typedef enum logic {
      CFG_BP = 1'b0,
      CFG_WP = 1'b1
   } cfg_kind_e;

   // Low address bits that an access of the given size spans.
   function automatic logic [1:0] lane_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 2'b00;
         2'd1:    return 2'b01;
         default: return 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
   import dbg_match_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2,
   parameter int SLOT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_kind,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              match
);

   logic              sel;
   logic [ADDR_W-1:0] addr_q;
   logic              en_q;

   assign sel = cfg_we && (cfg_kind == CFG_BP) && (cfg_idx == IDX_W'(SLOT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         en_q   <= 1'b0;
      end else if (sel) begin
         addr_q <= cfg_addr;
         en_q   <= cfg_en;
      end
   end

   assign match = en_q && (fetch_pc == addr_q);

endmodule

// File: rtl/dbg_wp_slot.sv
module dbg_wp_slot
   import dbg_match_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2,
   parameter int SLOT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_kind,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_mode,
   input  logic              mem_wr,
   input  logic [1:0]        mem_size,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              match
);

   logic              sel;
   logic [ADDR_W-1:0] addr_q;
   wp_mode_e          mode_q;
   logic [ADDR_W-1:0] ignore;
   logic              in_range;
   logic              dir_ok;

   assign sel = cfg_we && (cfg_kind == CFG_WP) && (cfg_idx == IDX_W'(SLOT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= WP_OFF;
      end else if (sel) begin
         addr_q <= cfg_addr;
         mode_q <= wp_mode_e'(cfg_mode);
      end
   end

   assign ignore   = {{(ADDR_W-2){1'b0}}, lane_mask(mem_size)};
   assign in_range = ((addr_q ^ mem_addr) & ~ignore) == '0;

   always_comb begin
      case (mode_q)
         WP_RD:   dir_ok = !mem_wr;
         WP_WR:   dir_ok = mem_wr;
         WP_RW:   dir_ok = 1'b1;
         default: dir_ok = 1'b0;
      endcase
   end

   assign match = in_range && dir_ok;

endmodule

// File: rtl/dbg_hit_arb.sv
module dbg_hit_arb #(
   parameter int NUM_BP = 4,
   parameter int NUM_WP = 4
) (
   input  logic              fetch_valid,
   input  logic              mem_valid,
   input  logic [NUM_BP-1:0] bp_match,
   input  logic [NUM_WP-1:0] wp_match,
   output logic              bp_hit,
   output logic              wp_hit,
   output logic              mem_inhibit
);

   logic bp_any;
   logic wp_any;

   assign bp_any      = fetch_valid && (|bp_match);
   assign wp_any      = mem_valid && (|wp_match);
   assign bp_hit      = bp_any;
   assign wp_hit      = wp_any && !bp_any;
   assign mem_inhibit = wp_any;

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
   parameter int ADDR_W = 32,
   parameter int NUM_BP = 4,
   parameter int NUM_WP = 4,
   localparam int MAX_SLOTS = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
   localparam int IDX_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_kind,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_ctrl,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              mem_valid,
   input  logic              mem_wr,
   input  logic [1:0]        mem_size,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              bp_hit,
   output logic              wp_hit,
   output logic              mem_inhibit
);

   if (ADDR_W < 3 || ADDR_W > 64) begin : g_bad_addr_w
      $error("dbg_match_unit: ADDR_W must lie in 3..64");
   end
   if (NUM_BP < 1 || NUM_BP > 32) begin : g_bad_num_bp
      $error("dbg_match_unit: NUM_BP must lie in 1..32");
   end
   if (NUM_WP < 1 || NUM_WP > 32) begin : g_bad_num_wp
      $error("dbg_match_unit: NUM_WP must lie in 1..32");
   end

   logic [NUM_BP-1:0] bp_match;
   logic [NUM_WP-1:0] wp_match;

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      dbg_bp_slot #(
         .ADDR_W (ADDR_W),
         .IDX_W  (IDX_W),
         .SLOT   (i)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .cfg_kind (cfg_kind),
         .cfg_idx  (cfg_idx),
         .cfg_addr (cfg_addr),
         .cfg_en   (cfg_ctrl[0]),
         .fetch_pc (fetch_pc),
         .match    (bp_match[i])
      );
   end

   for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
      dbg_wp_slot #(
         .ADDR_W (ADDR_W),
         .IDX_W  (IDX_W),
         .SLOT   (j)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .cfg_kind (cfg_kind),
         .cfg_idx  (cfg_idx),
         .cfg_addr (cfg_addr),
         .cfg_mode (cfg_ctrl),
         .mem_wr   (mem_wr),
         .mem_size (mem_size),
         .mem_addr (mem_addr),
         .match    (wp_match[j])
      );
   end

   dbg_hit_arb #(
      .NUM_BP (NUM_BP),
      .NUM_WP (NUM_WP)
   ) u_arb (
      .fetch_valid (fetch_valid),
      .mem_valid   (mem_valid),
      .bp_match    (bp_match),
      .wp_match    (wp_match),
      .bp_hit      (bp_hit),
      .wp_hit      (wp_hit),
      .mem_inhibit (mem_inhibit)
   );

endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic fetch_valid,
   input logic mem_valid,
   input logic bp_hit,
   input logic wp_hit,
   input logic mem_inhibit
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!bp_hit && !wp_hit && !mem_inhibit));

   // R10
   bp_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> fetch_valid);

   // R10
   wp_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_hit || mem_inhibit) |-> mem_valid);

   // R6
   wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> mem_inhibit);

   // R8
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bp_hit && wp_hit));

   // R8
   inhibit_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_inhibit && !bp_hit) |-> wp_hit);

endmodule

bind dbg_match_unit dbg_match_unit_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .mem_valid   (mem_valid),
   .bp_hit      (bp_hit),
   .wp_hit      (wp_hit),
   .mem_inhibit (mem_inhibit)
);

// File: tb/dbg_match_unit_test.sv
`timescale 1ns/1ps
module dbg_match_unit_test;

   localparam int AW = 32;
   localparam int NV = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_kind = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_addr = '0;
   logic [1:0]    cfg_ctrl = '0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic          mem_valid = 1'b0;
   logic          mem_wr = 1'b0;
   logic [1:0]    mem_size = '0;
   logic [AW-1:0] mem_addr = '0;
   logic          bp_hit, wp_hit, mem_inhibit;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dbg_match_unit #(.ADDR_W(AW), .NUM_BP(4), .NUM_WP(4)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
      .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_size(mem_size),
      .mem_addr(mem_addr),
      .bp_hit(bp_hit), .wp_hit(wp_hit), .mem_inhibit(mem_inhibit)
   );

   // {fetch_valid, fetch_pc, mem_valid, mem_wr, mem_size, mem_addr, exp bp/wp/inhibit}
   localparam logic [71:0] VEC [NV] = '{
      {1'b1, 32'h0000_1000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 3'b100}, // R2 exact
      {1'b1, 32'h0000_1004, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 3'b000}, // R2 off by a word
      {1'b1, 32'h0000_3000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 3'b000}, // R2 disabled slot
      {1'b1, 32'h0000_2004, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 3'b100}, // R2 other slot
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_8003, 3'b011}, // R3 load on load-only
      {1'b0, 32'h0000_0000, 1'b1, 1'b1, 2'd0, 32'h0000_8003, 3'b000}, // R3 store on load-only
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd2, 32'h0000_8000, 3'b011}, // R5 word covers byte 3
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd1, 32'h0000_8002, 3'b011}, // R5 upper half
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd1, 32'h0000_8000, 3'b000}, // R5 lower half
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_8004, 3'b000}, // R5 next byte
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd3, 32'h0000_A000, 3'b011}, // R5 size 3 as word
      {1'b0, 32'h0000_0000, 1'b1, 1'b1, 2'd2, 32'h0000_9000, 3'b011}, // R6 store blocked
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd2, 32'h0000_9000, 3'b000}, // R3 load on store-only
      {1'b0, 32'h0000_0000, 1'b1, 1'b1, 2'd0, 32'h0000_A001, 3'b011}, // R3 both, store
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_A001, 3'b011}, // R3 both, load
      {1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'd2, 32'h0000_B000, 3'b000}, // R4 off, load
      {1'b0, 32'h0000_0000, 1'b1, 1'b1, 2'd0, 32'h0000_B000, 3'b000}, // R4 off, store
      {1'b1, 32'h0000_1000, 1'b1, 1'b0, 2'd0, 32'h0000_8003, 3'b101}, // R8 both kinds hit
      {1'b0, 32'h0000_1000, 1'b0, 1'b0, 2'd0, 32'h0000_8003, 3'b000}, // R10 nothing valid
      {1'b0, 32'h0000_1000, 1'b1, 1'b0, 2'd0, 32'h0000_8003, 3'b011}, // R10 only data valid
      {1'b1, 32'h0000_2004, 1'b1, 1'b0, 2'd0, 32'h0000_8004, 3'b100}  // R8 bp, data misses
   };

   function automatic string row_req(input int i);
      if (i <= 3)       return "R2";
      else if (i <= 5)  return "R3";
      else if (i <= 10) return "R5";
      else if (i == 11) return "R6";
      else if (i <= 14) return "R3";
      else if (i <= 16) return "R4";
      else if (i == 17) return "R8";
      else if (i <= 19) return "R10";
      else              return "R8";
   endfunction

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic check3(input string req, input logic [2:0] exp);
      check(req, "bp_hit", bp_hit, exp[2]);
      check(req, "wp_hit", wp_hit, exp[1]);
      check(req, "mem_inhibit", mem_inhibit, exp[0]);
   endtask

   task automatic cfg_write(input logic kind, input logic [1:0] idx,
                            input logic [AW-1:0] addr, input logic [1:0] ctrl);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx;
      cfg_addr = addr; cfg_ctrl = ctrl;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic present(input logic fv, input logic [AW-1:0] pc,
                          input logic mv, input logic wr, input logic [1:0] sz,
                          input logic [AW-1:0] a);
      fetch_valid = fv; fetch_pc = pc;
      mem_valid = mv; mem_wr = wr; mem_size = sz; mem_addr = a;
      #1;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: requests during and right after reset; slot addresses are zero
      present(1'b1, 32'h0, 1'b1, 1'b1, 2'd2, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      present(1'b1, 32'h0, 1'b1, 1'b1, 2'd2, 32'h0);
      check3("R1", 3'b000);
      present(1'b1, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0);
      check3("R1", 3'b000);
      present(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);

      // arm the slots used by the table
      cfg_write(1'b0, 2'd0, 32'h0000_1000, 2'b01);
      cfg_write(1'b0, 2'd1, 32'h0000_3000, 2'b00);
      cfg_write(1'b0, 2'd2, 32'h0000_2004, 2'b01);
      cfg_write(1'b1, 2'd0, 32'h0000_8003, 2'b01);
      cfg_write(1'b1, 2'd1, 32'h0000_9000, 2'b10);
      cfg_write(1'b1, 2'd2, 32'h0000_A001, 2'b11);
      cfg_write(1'b1, 2'd3, 32'h0000_B000, 2'b00);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         present(VEC[i][71], VEC[i][70:39], VEC[i][38], VEC[i][37],
                 VEC[i][36:35], VEC[i][34:3]);
         check3(row_req(i), VEC[i][2:0]);
      end

      // R9: a write is not visible in its own cycle, only in the next
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 1'b0; cfg_idx = 2'd3;
      cfg_addr = 32'h0000_4000; cfg_ctrl = 2'b01;
      present(1'b1, 32'h0000_4000, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R9", "bp_hit same cycle as write", bp_hit, 1'b0);
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      check("R9", "bp_hit after write", bp_hit, 1'b1);

      // R9: clearing with a zero control field
      cfg_write(1'b0, 2'd3, 32'h0000_4000, 2'b00);
      present(1'b1, 32'h0000_4000, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R9", "bp_hit after clear", bp_hit, 1'b0);

      // R11: clearing the now empty slot again leaves the others armed
      cfg_write(1'b0, 2'd3, 32'h0, 2'b00);
      present(1'b1, 32'h0000_1000, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R11", "bp0 after empty clear", bp_hit, 1'b1);
      present(1'b1, 32'h0000_2004, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R11", "bp2 after empty clear", bp_hit, 1'b1);
      present(1'b0, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0000_8003);
      check("R11", "wp0 after empty clear", wp_hit, 1'b1);

      // R11: writing watchpoint 3 leaves breakpoint 3 alone
      cfg_write(1'b0, 2'd3, 32'h0000_4000, 2'b01);
      cfg_write(1'b1, 2'd3, 32'h0000_8000, 2'b11);
      present(1'b1, 32'h0000_4000, 1'b0, 1'b0, 2'd0, 32'h0);
      check("R11", "bp3 after wp3 write", bp_hit, 1'b1);

      // R7: wp0 and wp3 both lie in one word load, a single event
      present(1'b0, 32'h0, 1'b1, 1'b0, 2'd2, 32'h0000_8000);
      check3("R7", 3'b011);
      // R7: only wp3 (byte 0), wp0 mode excludes stores
      present(1'b0, 32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_8000);
      check3("R7", 3'b011);

      // R4: turning a watchpoint off silences it at its own address
      cfg_write(1'b1, 2'd2, 32'h0000_A001, 2'b00);
      present(1'b0, 32'h0, 1'b1, 1'b1, 2'd0, 32'h0000_A001);
      check3("R4", 3'b000);

      present(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule